// File: doc/BRIEF.md
# Flag-Based Comparison Decoder

This block compares two equal-width operands and answers one yes/no question about them. An internal ripple subtractor forms A minus B and produces four flags: zero, negative, borrow and signed overflow. A selector then turns one Boolean formula of those flags into the answer. A 4-bit condition code picks one of ten relations: equality, inequality, four signed orderings and four unsigned orderings. No relation uses a separate magnitude comparator. Every answer comes from the same four flags.

The answer is registered. An operand set presented with `in_valid` high at a rising clock edge produces `out_valid` and `result` just after that edge. The block has one operating condition (pipeline register filled or empty) and no further states. With `in_valid` low, the register holds a zero answer. In this block the carry flag means borrow: it is 1 exactly when A is below B taken as unsigned numbers.

Top module: `cmp_decoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `result` are both 0.
- R2: `out_valid` at a clock edge equals `in_valid` sampled at that edge. When it is 0, `result` is 0. An answer appears exactly one edge after its operands are sampled.
- R3: Code 0 gives 1 when A equals B. Code 1 gives 1 when A differs from B.
- R4: Code 2 gives signed A < B. Code 3 gives signed A <= B. Both treat the operands as two's complement.
- R5: Code 4 gives signed A > B. Code 5 gives signed A >= B.
- R6: Code 6 gives unsigned A < B. Code 7 gives unsigned A <= B.
- R7: Code 8 gives unsigned A > B. Code 9 gives unsigned A >= B.
- R8: Codes 10 through 15 always give 0.
- R9: The signed answers stay correct when the subtraction overflows. Two cases show this: A is the most negative value and B = 1, and A = 0 and B is the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are sampled this edge |
| opnd_a | input | DATA_W | Minuend A |
| opnd_b | input | DATA_W | Subtrahend B |
| cond_sel | input | 4 | Relation selector, encoding as in R3 to R8 |
| out_valid | output | 1 | Registered answer is present |
| result | output | 1 | Registered answer of the selected relation |

## Verification
Clocked assertions check several behaviours on every cycle. They check the idle-low answer and the one-edge timing of `out_valid`. They check the equality, signed-less-than and unsigned-less-than answers against direct numeric comparisons of the sampled operands, and they check that reserved codes answer 0. The other relations are not asserted. The full ten-code table, the overflow corner operands and the exact ordering of answers in a back-to-back stream are shown only by the bench scenarios, through its scoreboard.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [3:0] {
        CMP_EQ  = 4'd0,
        CMP_NE  = 4'd1,
        CMP_LT  = 4'd2,
        CMP_LE  = 4'd3,
        CMP_GT  = 4'd4,
        CMP_GE  = 4'd5,
        CMP_LTU = 4'd6,
        CMP_LEU = 4'd7,
        CMP_GTU = 4'd8,
        CMP_GEU = 4'd9
    } cmp_cond_e;

    // c_bor is a borrow: 1 when A < B unsigned
    typedef struct packed {
        logic z;
        logic n;
        logic c_bor;
        logic v;
    } cmp_flags_t;

endpackage

// File: rtl/cmp_subtractor.sv
module cmp_subtractor
    import cmp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sub_a,
    input  logic [DATA_W-1:0] sub_b,
    output cmp_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              carry_out;

    // A + ~B + 1, bit by bit
    always_comb begin
        logic cy;
        logic bn;
        cy = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
            bn      = ~sub_b[i];
            diff[i] = sub_a[i] ^ bn ^ cy;
            cy      = (sub_a[i] & bn) | (cy & (sub_a[i] ^ bn));
        end
        carry_out = cy;
    end

    always_comb begin
        flags.z     = (diff == '0);
        flags.n     = diff[MSB];
        flags.c_bor = ~carry_out;
        flags.v     = (sub_a[MSB] ^ sub_b[MSB]) & (diff[MSB] ^ sub_a[MSB]);
    end

endmodule

// File: rtl/cmp_flag_decode.sv
module cmp_flag_decode
    import cmp_pkg::*;
(
    input  cmp_flags_t  flags,
    input  logic [3:0]  cond_code,
    output logic        holds
);
    logic lt_s;

    always_comb begin
        lt_s = flags.n ^ flags.v;
        unique case (cmp_cond_e'(cond_code))
            CMP_EQ:  holds = flags.z;
            CMP_NE:  holds = ~flags.z;
            CMP_LT:  holds = lt_s;
            CMP_LE:  holds = flags.z | lt_s;
            CMP_GT:  holds = ~(flags.z | lt_s);
            CMP_GE:  holds = ~lt_s;
            CMP_LTU: holds = flags.c_bor;
            CMP_LEU: holds = flags.c_bor | flags.z;
            CMP_GTU: holds = ~(flags.c_bor | flags.z);
            CMP_GEU: holds = ~flags.c_bor;
            default: holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_decoder.sv
module cmp_decoder
    import cmp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        cond_sel,
    output logic              out_valid,
    output logic              result
);
    cmp_flags_t flags;
    logic       holds;
    logic       vld_q;
    logic       res_q;

    cmp_subtractor #(.DATA_W(DATA_W)) u_sub (
        .sub_a (opnd_a),
        .sub_b (opnd_b),
        .flags (flags)
    );

    cmp_flag_decode u_dec (
        .flags     (flags),
        .cond_code (cond_sel),
        .holds     (holds)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid & holds;
        end
    end

    always_comb begin
        out_valid = vld_q;
        result    = res_q;
    end

    // R2: output valid tracks the previous sample of in_valid
    a_r2_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: idle answer is zero
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !result);

    // R3: equality against a direct comparison
    a_r3_eq_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cond_sel) == 4'd0) |->
        (result == ($past(opnd_a) == $past(opnd_b))));

    // R4: signed less-than against a direct comparison
    a_r4_lt_signed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cond_sel) == 4'd2) |->
        (result == ($signed($past(opnd_a)) < $signed($past(opnd_b)))));

    // R6: unsigned less-than against a direct comparison
    a_r6_ltu_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cond_sel) == 4'd6) |->
        (result == ($past(opnd_a) < $past(opnd_b))));

    // R8: reserved codes answer zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cond_sel) >= 4'd10) |-> !result);

endmodule

// File: tb/sim_cmp_decoder.sv
module sim_cmp_decoder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [3:0]   cond_sel = '0;
    logic         out_valid;
    logic         result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit           q_exp[$];
    string        q_tag[$];
    logic [W-1:0] q_a[$];
    logic [W-1:0] q_b[$];
    logic [3:0]   q_c[$];

    always #4 clk = ~clk;  // 125 MHz

    cmp_decoder #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .out_valid(out_valid), .result(result)
    );

    function automatic bit ref_cmp(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
        logic signed [W-1:0] sa;
        logic signed [W-1:0] sb;
        sa = a;
        sb = b;
        case (c)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return sa < sb;
            4'd3: return sa <= sb;
            4'd4: return sa > sb;
            4'd5: return sa >= sb;
            4'd6: return a < b;
            4'd7: return a <= b;
            4'd8: return a > b;
            4'd9: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] c);
        if (c <= 4'd1) return "R3";
        if (c <= 4'd3) return "R4";
        if (c <= 4'd5) return "R5";
        if (c <= 4'd7) return "R6";
        if (c <= 4'd9) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c, string tag);
        @(negedge clk);
        opnd_a   = a;
        opnd_b   = b;
        cond_sel = c;
        in_valid = 1'b1;
        q_exp.push_back(ref_cmp(a, b, c));
        q_tag.push_back(tag);
        q_a.push_back(a);
        q_b.push_back(b);
        q_c.push_back(c);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_exp.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2 unexpected out_valid actual=1 expected=0");
            end else begin
                automatic bit           e = q_exp.pop_front();
                automatic string        t = q_tag.pop_front();
                automatic logic [W-1:0] a = q_a.pop_front();
                automatic logic [W-1:0] b = q_b.pop_front();
                automatic logic [3:0]   c = q_c.pop_front();
                check(t, result, e, $sformatf("a=%h b=%h code=%0d", a, b, c));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr;
        logic [W-1:0] pats_a [8];
        logic [W-1:0] pats_b [8];
        pats_a = '{16'h0005, 16'h0003, 16'h0007, 16'hFFFF, 16'h8000, 16'h0000, 16'h7FFF, 16'h0000};
        pats_b = '{16'h0005, 16'h0007, 16'h0003, 16'h0001, 16'h0001, 16'h8000, 16'h8000, 16'hFFFF};

        repeat (3) @(negedge clk);
        check("R1", out_valid, 1'b0, "out_valid in reset");
        check("R1", result, 1'b0, "result in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", out_valid, 1'b0, "out_valid idle after reset");

        // every code over a fixed pattern set
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 16; c++) begin
                drive(pats_a[p], pats_b[p], 4'(c), tag_of(4'(c)));
            end
        end

        // overflow corners for the signed relations
        for (int c = 2; c < 6; c++) begin
            drive(16'h8000, 16'h0001, 4'(c), "R9");
            drive(16'h0000, 16'h8000, 4'(c), "R9");
        end

        idle(2);
        check("R2", out_valid, 1'b0, "out_valid after stream");
        check("R2", result, 1'b0, "result after stream");

        // pseudo-random stream with gaps
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb = (k % 5 == 0) ? ra : lfsr;
            drive(ra, rb, 4'(k % 16), tag_of(4'(k % 16)));
            if (k % 7 == 0) idle(1);
        end

        idle(3);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL R2 pending answers actual=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule